// File: doc/BRIEF.md
# Single-Line Input Expander Read Sequencer

This block reads a chain of cascaded, double-buffered parallel-in/serial-out input expanders. It uses one control line and a serial clock and data pair in SPI mode 0. Outside the block, the control line drives each expander's output-enable (active low) directly. An inverter feeds both the storage-register clock and the active-low load input. A single level change on that line therefore acts on capture, load and output enable together.

On a start request the sequencer drives the line through four steps: low, then high, then low, with each step held for a set number of clock cycles. The first low step gives a rising storage clock, which captures the input pins. The high step asserts load, which copies the storage stage into the shifter. The second low step releases load and enables the serial output. The block then clocks out eight bits per device in one unbroken burst, with no control change between devices. It returns the line high, presents the assembled word, and pulses done for one cycle.

The result has `8*N_DEV` bits. The first byte received, which comes from the device nearest the MISO pin, lands in the most significant byte, and each byte arrives most significant bit first.

Top module: `expander_read_seq`

## Requirements
- R1: While reset is high, and on the first cycle after it, `ctl_o`=1, `sck_o`=0, `busy_o`=0, `done_o`=0 and `data_o`=0.
- R2: A start accepted while idle makes `ctl_o` go low on the next cycle. It stays low for STEP cycles, then high for STEP cycles, then low for STEP cycles. STEP is the larger of `HOLD_CYC` and `2*SCK_HALF`. `sck_o` stays low throughout these steps.
- R3: `sck_o` idles low. Each high phase and each low phase lasts `SCK_HALF` cycles. A read produces exactly `8*N_DEV` rising edges.
- R4: `miso_i` is sampled at the clock edge that raises `sck_o`, and each byte arrives most significant bit first. The first byte received lands in `data_o[8*N_DEV-1 -: 8]`.
- R5: Input pins are captured on the first low step. Pin changes made after that step has begun do not appear in the result.
- R6: The edge that ends the last high phase sets `ctl_o`=1, `busy_o`=0 and `done_o`=1 together. `done_o` lasts exactly one cycle.
- R7: A start request that arrives while `busy_o` is high is ignored. It does not extend the read and does not produce a second done.
- R8: `ctl_o` stays low for the whole serial burst across all devices, so `sck_o` is never high while `ctl_o` is high.
- R9: `data_o` changes only in the cycle in which `done_o` is high, and it holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Read request, sampled while idle |
| miso_i | input | 1 | Serial data from the expander chain |
| ctl_o | output | 1 | Control line (drives output enable; its inverse drives storage clock and load) |
| sck_o | output | 1 | Serial clock, mode 0 |
| data_o | output | 8*N_DEV | Assembled result, first byte received in the top byte |
| busy_o | output | 1 | A read is in progress |
| done_o | output | 1 | One-cycle pulse when `data_o` is valid |

## Verification
The assertions assume that reset is held for at least one clock edge, and that `start_i` is a synchronous level sampled at the rising clock edge. They also assume `miso_i` is stable at the edge that raises `sck_o`. The bench meets these assumptions as follows. It drives every input on the falling clock edge. Its expander model updates MISO only on serial clock edges. It captures the storage stage on the falling edge of the control line and loads the shifter while the line is high, so MISO never moves at the sampling edge.

// File: rtl/exr_pkg.sv
package exr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CAP   = 3'd1,
    ST_LOAD  = 3'd2,
    ST_ENA   = 3'd3,
    ST_XFER  = 3'd4
  } exr_state_t;

  function automatic int unsigned exr_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/exr_sck_gen.sv
module exr_sck_gen #(
  parameter int unsigned SCK_HALF = 2,
  parameter int unsigned NBITS    = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  output logic sck_o,
  output logic rise_o,
  output logic last_o
);
  localparam int unsigned HW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam int unsigned BW = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam logic [HW-1:0] HALF_END = HW'(SCK_HALF - 1);
  localparam logic [BW-1:0] BIT_END  = BW'(NBITS - 1);

  logic [HW-1:0] half_cnt;
  logic [BW-1:0] bit_cnt;
  logic          phase_end;

  assign phase_end = en_i && (half_cnt == HALF_END);
  assign rise_o    = phase_end && !sck_o;
  assign last_o    = phase_end && sck_o && (bit_cnt == BIT_END);

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      half_cnt <= '0;
      bit_cnt  <= '0;
      sck_o    <= 1'b0;
    end else if (phase_end) begin
      half_cnt <= '0;
      sck_o    <= ~sck_o;
      if (sck_o) bit_cnt <= bit_cnt + 1'b1;
    end else begin
      half_cnt <= half_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/exr_capture.sv
module exr_capture #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_i,
  input  logic             commit_i,
  input  logic             miso_i,
  output logic [WIDTH-1:0] data_o
);
  logic [WIDTH-1:0] shreg;

  generate
    if (WIDTH > 1) begin : g_wide
      always_ff @(posedge clk) begin
        if (rst)          shreg <= '0;
        else if (shift_i) shreg <= {shreg[WIDTH-2:0], miso_i};
      end
    end else begin : g_narrow
      always_ff @(posedge clk) begin
        if (rst)          shreg <= '0;
        else if (shift_i) shreg <= miso_i;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)           data_o <= '0;
    else if (commit_i) data_o <= shreg;
  end
endmodule

// File: rtl/exr_ctrl_fsm.sv
module exr_ctrl_fsm
  import exr_pkg::*;
#(
  parameter int unsigned STEP = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic last_i,
  output logic ctl_o,
  output logic busy_o,
  output logic done_o,
  output logic xfer_o
);
  localparam int unsigned SW = (STEP > 1) ? $clog2(STEP) : 1;
  localparam logic [SW-1:0] STEP_END = SW'(STEP - 1);

  exr_state_t state;
  logic [SW-1:0] step_cnt;
  logic step_end;

  assign step_end = (step_cnt == STEP_END);
  assign xfer_o   = (state == ST_XFER);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      step_cnt <= '0;
      ctl_o    <= 1'b1;
      busy_o   <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        ST_IDLE: begin
          step_cnt <= '0;
          if (start_i) begin
            state  <= ST_CAP;
            ctl_o  <= 1'b0;
            busy_o <= 1'b1;
          end
        end
        ST_CAP: begin
          step_cnt <= step_end ? '0 : step_cnt + 1'b1;
          if (step_end) begin
            state <= ST_LOAD;
            ctl_o <= 1'b1;
          end
        end
        ST_LOAD: begin
          step_cnt <= step_end ? '0 : step_cnt + 1'b1;
          if (step_end) begin
            state <= ST_ENA;
            ctl_o <= 1'b0;
          end
        end
        ST_ENA: begin
          step_cnt <= step_end ? '0 : step_cnt + 1'b1;
          if (step_end) state <= ST_XFER;
        end
        ST_XFER: begin
          if (last_i) begin
            state  <= ST_IDLE;
            ctl_o  <= 1'b1;
            busy_o <= 1'b0;
            done_o <= 1'b1;
          end
        end
        default: begin
          state  <= ST_IDLE;
          ctl_o  <= 1'b1;
          busy_o <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/expander_read_seq.sv
module expander_read_seq
  import exr_pkg::*;
#(
  parameter int unsigned N_DEV    = 2,
  parameter int unsigned HOLD_CYC = 6,
  parameter int unsigned SCK_HALF = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               miso_i,
  output logic               ctl_o,
  output logic               sck_o,
  output logic [8*N_DEV-1:0] data_o,
  output logic               busy_o,
  output logic               done_o
);
  localparam int unsigned NBITS = 8 * N_DEV;
  localparam int unsigned STEP  = exr_max(HOLD_CYC, 2 * SCK_HALF);

  logic xfer, rise, last;

  exr_ctrl_fsm #(.STEP(STEP)) u_fsm (
    .clk(clk), .rst(rst), .start_i(start_i), .last_i(last),
    .ctl_o(ctl_o), .busy_o(busy_o), .done_o(done_o), .xfer_o(xfer)
  );

  exr_sck_gen #(.SCK_HALF(SCK_HALF), .NBITS(NBITS)) u_sck (
    .clk(clk), .rst(rst), .en_i(xfer),
    .sck_o(sck_o), .rise_o(rise), .last_o(last)
  );

  exr_capture #(.WIDTH(NBITS)) u_cap (
    .clk(clk), .rst(rst), .shift_i(rise), .commit_i(last),
    .miso_i(miso_i), .data_o(data_o)
  );
endmodule

// File: rtl/expander_read_seq_chk.sv
module expander_read_seq_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         start_i,
  input logic         ctl_o,
  input logic         sck_o,
  input logic [W-1:0] data_o,
  input logic         busy_o,
  input logic         done_o
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (ctl_o && !sck_o && !busy_o && !done_o && data_o == '0));

  a_r2_start_drops_ctl: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !done_o && start_i) |=> (!ctl_o && busy_o));

  a_r3_sck_idle_low: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !sck_o);

  a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r6_done_idle_line: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (ctl_o && !busy_o));

  a_r7_busy_needs_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i));

  a_r8_line_low_in_burst: assert property (@(posedge clk) disable iff (rst)
    sck_o |-> !ctl_o);

  a_r9_data_held: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(data_o));
endmodule

bind expander_read_seq expander_read_seq_chk #(.W(8*N_DEV)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .ctl_o(ctl_o), .sck_o(sck_o),
  .data_o(data_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/test_expander_read_seq.sv
module test_expander_read_seq;
  localparam int N  = 2;
  localparam int HC = 6;
  localparam int SH = 2;
  localparam int S  = (HC > 2*SH) ? HC : 2*SH;
  localparam int W  = 8*N;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic miso;
  logic ctl, sck, busy, done;
  logic [W-1:0] data;

  int errs = 0;
  int checks = 0;
  int dones = 0;
  int reads = 0;
  bit finished = 0;

  logic [W-1:0] expq[$];
  logic [7:0] pins [N];
  logic [7:0] store [N];
  logic [7:0] shr [N];

  always #4 clk = ~clk;

  expander_read_seq #(.N_DEV(N), .HOLD_CYC(HC), .SCK_HALF(SH)) i_expander_read_seq (
    .clk(clk), .rst(rst), .start_i(start), .miso_i(miso), .ctl_o(ctl),
    .sck_o(sck), .data_o(data), .busy_o(busy), .done_o(done)
  );

  // Expander chain model: storage clock = ~ctl, load_n = ~ctl, oe_n = ctl
  always @(negedge ctl)
    for (int d = 0; d < N; d++) store[d] <= pins[d];

  always @(posedge ctl or posedge sck)
    if (ctl) begin
      for (int d = 0; d < N; d++) shr[d] <= store[d];
    end else begin
      for (int d = 0; d < N; d++)
        shr[d] <= {shr[d][6:0], (d == N-1) ? 1'b0 : shr[d+1][7]};
    end

  assign miso = ctl ? 1'b0 : shr[0][7];

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  // Monitor: scoreboard, serial clock shape, line state in burst
  int rises = 0;
  int hirun = 0;
  int lorun = 0;
  bit prev_sck = 0;
  bit prev_done = 0;
  logic [W-1:0] held;
  always @(negedge clk) if (!rst) begin
    if (sck && !prev_sck) rises++;
    if (sck) hirun++;
    if (!sck && prev_sck) begin
      chk(hirun == SH, "R3 high phase", W'(hirun), W'(SH));
      hirun = 0;
    end
    if (busy && !sck && rises > 0 && rises < W) lorun++;
    if (sck && !prev_sck && rises > 1) begin
      chk(lorun == SH, "R3 low phase", W'(lorun), W'(SH));
    end
    if (sck && !prev_sck) lorun = 0;
    if (sck && ctl) chk(0, "R8 line high during burst", W'(ctl), 0);
    if (prev_done) chk(!done, "R6 done width", W'(done), 0);
    if (done) begin
      logic [W-1:0] e;
      dones++;
      chk(rises == W, "R3 rising edges per read", W'(rises), W'(W));
      chk(ctl && !busy && !sck, "R6 idle at done", {ctl, busy, sck}, 3'b100);
      if (expq.size() == 0) chk(0, "R7 unexpected done", data, 0);
      else begin
        e = expq.pop_front();
        chk(data == e, "R4/R5 result", data, e);
      end
      rises = 0;
      lorun = 0;
      held = data;
    end else if (!busy && dones > 0) begin
      if (data != held) chk(0, "R9 data held", data, held);
    end
    prev_sck = sck;
    prev_done = done;
  end

  task automatic do_read(input logic [W-1:0] v, input bit chg_mid, input bit start_mid);
    int bad = 0;
    int sckbad = 0;
    @(negedge clk);
    for (int d = 0; d < N; d++) pins[d] = v[W-1-8*d -: 8];
    expq.push_back(v);
    reads++;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 3*S; k++) begin
      if (ctl !== ((k >= S && k < 2*S) ? 1'b1 : 1'b0)) bad++;
      if (sck) sckbad++;
      if (chg_mid && k == S)
        for (int d = 0; d < N; d++) pins[d] = ~pins[d];
      start = (start_mid && (k == 2 || k == 2*S + 1));
      @(negedge clk);
    end
    start = 1'b0;
    chk(bad == 0, "R2 control step pattern", W'(bad), 0);
    chk(sckbad == 0, "R2 sck low during steps", W'(sckbad), 0);
    while (busy) begin
      if (start_mid) start = 1'b1;
      @(negedge clk);
    end
    start = 1'b0;
    repeat (4) @(negedge clk);
    chk(!busy && ctl, "R7 no restart after read", {busy, ctl}, 2'b01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 0);
    finish_run();
  end

  initial begin
    for (int d = 0; d < N; d++) pins[d] = 8'h00;
    repeat (3) @(negedge clk);
    chk(ctl && !sck && !busy && !done && data == '0, "R1 reset in", {ctl, sck, busy, done}, 4'b1000);
    rst = 1'b0;
    @(negedge clk);
    chk(ctl && !sck && !busy && !done && data == '0, "R1 reset out", {ctl, sck, busy, done}, 4'b1000);
    do_read(16'hA55A, 0, 0);   // R4 mixed pattern
    do_read(16'h8001, 0, 0);   // R4 ends of each byte
    do_read(16'hFF00, 0, 0);   // R4 byte order
    do_read(16'h3C96, 1, 0);   // R5 pins flip during load step
    do_read(16'h1234, 0, 1);   // R7 starts while busy
    do_read(16'h0000, 0, 0);
    do_read(16'hFFFF, 0, 0);
    repeat (10) @(negedge clk);
    chk(dones == reads, "R7 done count", W'(dones), W'(reads));
    chk(expq.size() == 0, "R4 scoreboard empty", W'(expq.size()), 0);
    finish_run();
  end
endmodule